// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge is a bus slave placed in front of a memory or peripheral region. Software gets a 32 MiB alias window in which every aligned alias word stands for exactly one bit of the real region. A read through the window returns that bit as 0 or 1. A write through the window sets or clears that bit and leaves every other bit of the target untouched. The bridge turns each alias access into accesses of the same size on the real target. A read becomes one downstream read. A write becomes a downstream read followed by a write-back, and the downstream bus is locked between the two so that nothing else can get in.

The target region is fixed by a parameter. In a system, one instance serves the SRAM region at 0x2000_0000 through the alias window at 0x2200_0000. A second instance serves the peripheral region at 0x4000_0000 through the window at 0x4200_0000. Both sides use valid/ready handshakes. Downstream data is little-endian and right-justified: byte n of the target value travels on bits 8n+7..8n.

Top module: `bitband_bridge`

## Requirements
- R1: After reset the bridge is idle. `up_ready` is 1, and `dn_req_valid`, `dn_lock` and `up_resp_valid` are 0.
- R2: The alias offset is bits 24:0 of `up_addr`. Address bits above bit 24 have no effect. The downstream address is `TARGET_BASE | (offset >> 5)`. For halfword accesses bit 0 of that address is cleared, and for word accesses bits 1:0 are cleared.
- R3: The bit index is `offset[6:2]`, kept to its low 3 bits for a byte, 4 bits for a halfword and 5 bits for a word. Bit n of the target value is bit n%8 of byte address + n/8.
- R4: The size code is 0 = byte, 1 = halfword, 2 = word, and code 3 is treated as word. Every downstream request carries the size of the alias access.
- R5: An alias read issues exactly one downstream read. `up_resp_valid` rises in the cycle after `dn_rvalid`, and `up_rdata` is 1 if the selected bit is set and 0 otherwise, with bits 31:1 zero.
- R6: An alias write reads the target and then writes it back to the same address at the same size. The selected bit becomes `up_wdata[0]` and every other bit within the access size keeps its value.
- R7: For an alias write, `dn_lock` is high from the cycle after acceptance through the cycle in which the write-back is accepted, and low otherwise. No other downstream request is made between the read and the write-back. Alias reads never assert `dn_lock`.
- R8: A write response (`up_rdata` = 0) is given in the cycle after the write-back is accepted, and never before it.
- R9: `up_ready` is 0 from the cycle after a request is accepted until the cycle after its response. A request presented during that time is ignored and causes no downstream access.
- R10: `TARGET_BASE` selects the target region. With 0x2000_0000 and 0x4000_0000 the same alias offset reaches the corresponding address in each region.
- R11: While `dn_req_valid` is high and `dn_req_ready` is low, the request stays valid and its address, size and write flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge can accept a request |
| up_addr | input | ADDR_W | Alias address |
| up_size | input | 2 | Access size code |
| up_write | input | 1 | 1 = alias write |
| up_wdata | input | DATA_W | Write data; only bit 0 is used |
| up_resp_valid | output | 1 | One-cycle response strobe |
| up_rdata | output | DATA_W | Read result, 0 or 1 |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_addr | output | ADDR_W | Target byte address |
| dn_size | output | 2 | Target access size code |
| dn_write | output | 1 | 1 = write-back, 0 = read |
| dn_wdata | output | DATA_W | Write-back value, right-justified |
| dn_lock | output | 1 | Downstream bus held for a read-modify-write |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | DATA_W | Downstream read data, right-justified |

## Verification
The hardest case to reach from the ports is a read-modify-write that is stretched out by a slow target. In that case the lock must stay high across the stalled read request, the read latency and the stalled write-back, while upstream traffic keeps knocking. The bench gets there by giving the downstream responder random ready stalls and a random read latency of one to three cycles. During some writes it also holds a second upstream request, with different fields, for the whole time the bridge is busy, and drops it just before the response. The reference model checks every cycle that the lock, the ready and the request lines match the phase it expects. The model also runs behaviour at addresses above bit 24 and on the peripheral instance through the same stimulus path.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_RESP    = 3'd4
    } bb_state_e;

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              OFFSET_W    = 25,
    parameter int              BIT_W       = 5,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic [ADDR_W-1:0] alias_addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [BIT_W-1:0]  bit_idx
);
    // one alias word per bit, eight bits per byte
    localparam int WORD_SHIFT = 2;
    localparam int BYTE_BITS  = 3;
    localparam int TGT_SHIFT  = WORD_SHIFT + BYTE_BITS;

    logic [OFFSET_W-1:0] offset;
    logic [ADDR_W-1:0]   byte_addr;
    logic [BIT_W-1:0]    raw_bit;
    logic                unused_hi_bits;

    assign offset         = alias_addr[OFFSET_W-1:0];
    assign unused_hi_bits = ^alias_addr[ADDR_W-1:OFFSET_W];
    assign byte_addr      = TARGET_BASE | ADDR_W'(offset >> TGT_SHIFT);
    assign raw_bit        = offset[WORD_SHIFT +: BIT_W];

    always_comb begin
        case (size)
            SZ_BYTE: begin
                tgt_addr = byte_addr;
                bit_idx  = raw_bit & BIT_W'(7);
            end
            SZ_HALF: begin
                tgt_addr = {byte_addr[ADDR_W-1:1], 1'b0};
                bit_idx  = raw_bit & BIT_W'(15);
            end
            default: begin
                tgt_addr = {byte_addr[ADDR_W-1:2], 2'b00};
                bit_idx  = raw_bit;
            end
        endcase
    end

endmodule

// File: rtl/bb_bit_ops.sv
module bb_bit_ops #(
    parameter int DATA_W = 32,
    parameter int BIT_W  = 5
) (
    input  logic [DATA_W-1:0] rd_value,
    input  logic [1:0]        size,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              set_bit,
    output logic              bit_val,
    output logic [DATA_W-1:0] new_value
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] onehot;
    logic [DATA_W-1:0] kept;

    // lanes beyond the access size never reach the write-back
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign size_mask[g*8 +: 8] = (g < (1 << size)) ? 8'hFF : 8'h00;
    end

    assign onehot    = DATA_W'(1) << bit_idx;
    assign kept      = rd_value & size_mask;
    assign bit_val   = |(rd_value & onehot);
    assign new_value = set_bit ? (kept | onehot) : (kept & ~onehot);

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter int                OFFSET_W    = 25,
    parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [1:0]        up_size,
    input  logic              up_write,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_resp_valid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [1:0]        dn_size,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic              dn_lock,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata
);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        bb_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic [BIT_W-1:0]  bit_idx;
        logic              is_wr;
        logic              set_bit;
        logic [DATA_W-1:0] wval;
        logic              rbit;
        logic              lock;
    } regs_t;

    localparam regs_t RESET_VAL = '0;

    regs_t q, d;

    logic [1:0]        size_norm;
    logic [ADDR_W-1:0] map_addr;
    logic [BIT_W-1:0]  map_bit;
    logic              ops_bit;
    logic [DATA_W-1:0] ops_new;
    logic              unused_wdata_hi;

    assign size_norm       = (up_size == 2'd3) ? SZ_WORD : up_size;
    assign unused_wdata_hi = ^up_wdata[DATA_W-1:1];

    bb_addr_map #(
        .ADDR_W     (ADDR_W),
        .OFFSET_W   (OFFSET_W),
        .BIT_W      (BIT_W),
        .TARGET_BASE(TARGET_BASE)
    ) u_map (
        .alias_addr(up_addr),
        .size      (size_norm),
        .tgt_addr  (map_addr),
        .bit_idx   (map_bit)
    );

    bb_bit_ops #(
        .DATA_W(DATA_W),
        .BIT_W (BIT_W)
    ) u_ops (
        .rd_value (dn_rdata),
        .size     (q.size),
        .bit_idx  (q.bit_idx),
        .set_bit  (q.set_bit),
        .bit_val  (ops_bit),
        .new_value(ops_new)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (up_valid) begin
                    d.st      = ST_RD_REQ;
                    d.addr    = map_addr;
                    d.size    = size_norm;
                    d.bit_idx = map_bit;
                    d.is_wr   = up_write;
                    d.set_bit = up_wdata[0];
                    d.rbit    = 1'b0;
                    d.lock    = up_write;
                end
            end
            ST_RD_REQ: begin
                if (dn_req_ready) d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (dn_rvalid) begin
                    if (q.is_wr) begin
                        d.wval = ops_new;
                        d.st   = ST_WR_REQ;
                    end else begin
                        d.rbit = ops_bit;
                        d.st   = ST_RESP;
                    end
                end
            end
            ST_WR_REQ: begin
                if (dn_req_ready) begin
                    d.st   = ST_RESP;
                    d.lock = 1'b0;
                end
            end
            ST_RESP: begin
                d.st   = ST_IDLE;
                d.rbit = 1'b0;
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign up_ready      = (q.st == ST_IDLE);
    assign up_resp_valid = (q.st == ST_RESP);
    assign up_rdata      = {{(DATA_W-1){1'b0}}, q.rbit};
    assign dn_req_valid  = (q.st == ST_RD_REQ) || (q.st == ST_WR_REQ);
    assign dn_write      = (q.st == ST_WR_REQ);
    assign dn_addr       = q.addr;
    assign dn_size       = q.size;
    assign dn_wdata      = q.wval;
    assign dn_lock       = q.lock;

    // write-back only under lock
    p_lock_covers_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_write) |-> dn_lock);

    // lock released once the write-back is taken
    p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready && dn_write) |=> !dn_lock);

    // stalled request is held
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_addr)
                                             && $stable(dn_size) && $stable(dn_write)));

    // no new upstream request while downstream work is open
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid || dn_lock) |-> !up_ready);

    // response carries a single bit
    p_resp_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        up_resp_valid |-> ((up_rdata >> 1) == '0));

    // write response follows the accepted write-back
    p_wr_resp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_ready && dn_write) |=> up_resp_valid);

    // size code 3 never reaches the target bus
    p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> (dn_size != 2'd3));

endmodule

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;
    logic rst_n = 1'b0;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // upstream stimulus
    logic        sel = 1'b0;
    logic        up_valid = 1'b0;
    logic [31:0] up_addr = '0;
    logic [1:0]  up_size = '0;
    logic        up_write = 1'b0;
    logic [31:0] up_wdata = '0;

    // downstream responder
    logic        dn_ready = 1'b0;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;

    logic        rdy_a, rsp_a, req_a, wr_a, lck_a;
    logic [31:0] rd_a, ad_a, wd_a;
    logic [1:0]  sz_a;
    logic        rdy_b, rsp_b, req_b, wr_b, lck_b;
    logic [31:0] rd_b, ad_b, wd_b;
    logic [1:0]  sz_b;

    bitband_bridge #(.TARGET_BASE(32'h2000_0000)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid && !sel), .up_ready(rdy_a), .up_addr(up_addr),
        .up_size(up_size), .up_write(up_write), .up_wdata(up_wdata),
        .up_resp_valid(rsp_a), .up_rdata(rd_a),
        .dn_req_valid(req_a), .dn_req_ready(dn_ready && !sel), .dn_addr(ad_a),
        .dn_size(sz_a), .dn_write(wr_a), .dn_wdata(wd_a), .dn_lock(lck_a),
        .dn_rvalid(dn_rvalid && !sel), .dn_rdata(dn_rdata)
    );

    bitband_bridge #(.TARGET_BASE(32'h4000_0000)) uut_p (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid && sel), .up_ready(rdy_b), .up_addr(up_addr),
        .up_size(up_size), .up_write(up_write), .up_wdata(up_wdata),
        .up_resp_valid(rsp_b), .up_rdata(rd_b),
        .dn_req_valid(req_b), .dn_req_ready(dn_ready && sel), .dn_addr(ad_b),
        .dn_size(sz_b), .dn_write(wr_b), .dn_wdata(wd_b), .dn_lock(lck_b),
        .dn_rvalid(dn_rvalid && sel), .dn_rdata(dn_rdata)
    );

    wire        m_ready = sel ? rdy_b : rdy_a;
    wire        m_resp  = sel ? rsp_b : rsp_a;
    wire [31:0] m_rdata = sel ? rd_b  : rd_a;
    wire        m_req   = sel ? req_b : req_a;
    wire [31:0] m_daddr = sel ? ad_b  : ad_a;
    wire [1:0]  m_dsize = sel ? sz_b  : sz_a;
    wire        m_dwr   = sel ? wr_b  : wr_a;
    wire [31:0] m_dwd   = sel ? wd_b  : wd_a;
    wire        m_lock  = sel ? lck_b : lck_a;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // target memory written by the bridge, and the golden copy kept by the model
    logic [7:0] mem  [int unsigned];
    logic [7:0] gold [int unsigned];

    function automatic logic [7:0] seed_byte(int unsigned a);
        return 8'((a * 151) ^ (a >> 8) ^ 32'h3c);
    endfunction
    function automatic logic [7:0] mem_rd(int unsigned a);
        return mem.exists(a) ? mem[a] : seed_byte(a);
    endfunction
    function automatic logic [7:0] gold_rd(int unsigned a);
        return gold.exists(a) ? gold[a] : seed_byte(a);
    endfunction

    // model of one transaction
    bit          busy = 0;
    bit          lock_exp = 0;
    int          phase = 4;      // 0 read req, 1 wait data, 2 write req, 3 response, 4 none
    int          rv_cnt = 0;
    int          cyc = 0;
    int          resp_due = 0;
    int          acc_cnt = 0;
    logic [31:0] e_addr;
    logic [1:0]  e_size;
    int          e_nb;
    bit          e_wr;
    bit          e_rbit;

    task automatic model_accept();
        logic [31:0] off, base, byte_a;
        int bi;
        base   = sel ? 32'h4000_0000 : 32'h2000_0000;
        off    = up_addr & 32'h01FF_FFFF;
        byte_a = base | (off >> 5);
        bi     = int'(off >> 2);
        case (up_size)
            2'd0:    begin e_nb = 1; e_addr = byte_a;          bi = bi % 8;  e_size = 2'd0; end
            2'd1:    begin e_nb = 2; e_addr = byte_a & ~32'h1; bi = bi % 16; e_size = 2'd1; end
            default: begin e_nb = 4; e_addr = byte_a & ~32'h3; bi = bi % 32; e_size = 2'd2; end
        endcase
        e_wr   = up_write;
        e_rbit = gold_rd(e_addr + bi / 8)[bi % 8];
        if (e_wr) begin
            logic [7:0] b;
            b = gold_rd(e_addr + bi / 8);
            b[bi % 8] = up_wdata[0];
            gold[e_addr + bi / 8] = b;
        end
    endtask

    always @(negedge clk) begin
        dn_ready  = ($urandom_range(0, 3) != 0);
        dn_rvalid = 1'b0;
        if (rv_cnt > 0) begin
            rv_cnt--;
            if (rv_cnt == 0) begin
                logic [31:0] v;
                v = 32'hA5C3_5A3C;
                for (int i = 0; i < e_nb; i++) v[8*i +: 8] = mem_rd(e_addr + i);
                dn_rvalid = 1'b1;
                dn_rdata  = v;
            end
        end
        #1;
        if (rst_n && !finished) begin
            cyc++;
            chk(m_ready == !busy, "R9 up_ready", 32'(m_ready), 32'(!busy));
            chk(m_lock == lock_exp, "R7 lock", 32'(m_lock), 32'(lock_exp));
            chk(m_req == (busy && (phase == 0 || phase == 2)), "R7 request window",
                32'(m_req), 32'(phase));
            if (m_req && dn_ready) begin
                chk(m_daddr == e_addr, "R2 target address", m_daddr, e_addr);
                chk(m_dsize == e_size, "R4 target size", 32'(m_dsize), 32'(e_size));
                if (phase == 0) begin
                    chk(!m_dwr, "R6 read first", 32'(m_dwr), 0);
                    phase  = 1;
                    rv_cnt = $urandom_range(1, 3);
                end else if (phase == 2) begin
                    chk(m_dwr, "R6 write-back", 32'(m_dwr), 1);
                    for (int i = 0; i < e_nb; i++) mem[m_daddr + i] = m_dwd[8*i +: 8];
                    phase    = 3;
                    resp_due = cyc + 1;
                    lock_exp = 0;
                end
            end
            if (dn_rvalid && phase == 1) begin
                if (e_wr) phase = 2;
                else begin
                    phase    = 3;
                    resp_due = cyc + 1;
                end
            end
            if (phase == 3 && cyc == resp_due) begin
                chk(m_resp, e_wr ? "R8 write response timing" : "R5 read response timing",
                    32'(m_resp), 1);
                if (e_wr) begin
                    chk(m_rdata == 0, "R8 write response data", m_rdata, 0);
                    for (int i = 0; i < 4; i++)
                        chk(mem_rd((e_addr & ~32'h3) + i) == gold_rd((e_addr & ~32'h3) + i),
                            "R6 target bits", 32'(mem_rd((e_addr & ~32'h3) + i)),
                            32'(gold_rd((e_addr & ~32'h3) + i)));
                end else begin
                    chk(m_rdata == 32'(e_rbit), "R5 read bit", m_rdata, 32'(e_rbit));
                end
                busy  = 0;
                phase = 4;
            end else if (m_resp) begin
                chk(0, "R8 stray response", 32'(m_resp), 0);
            end
            if (up_valid && m_ready && !busy) begin
                model_accept();
                busy     = 1;
                phase    = 0;
                lock_exp = e_wr;
                acc_cnt++;
            end
        end
    end

    task automatic op(input logic s, input logic [31:0] a, input logic [1:0] sz,
                      input bit w, input bit v, input bit intrude);
        int start;
        @(posedge clk); #1;
        sel = s; up_valid = 1'b1; up_addr = a; up_size = sz; up_write = w;
        up_wdata = {31'h5555_AAAA, v};
        start = acc_cnt;
        while (acc_cnt == start) @(posedge clk);
        #1;
        if (intrude) begin
            up_addr  = a ^ 32'h0000_1F04;
            up_write = 1'b1;
            up_wdata = {31'h0, !v};
            while (phase != 3) @(posedge clk);
            #1;
        end
        up_valid = 1'b0;
        while (busy) @(posedge clk);
        if (intrude)
            chk(acc_cnt == start + 1, "R9 ignored while busy", 32'(acc_cnt), 32'(start + 1));
    endtask

    // read an alias bit and compare with the model's golden memory
    task automatic rd(input logic s, input logic [31:0] a, input logic [1:0] sz);
        op(s, a, sz, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state on both instances
        chk(rdy_a && rdy_b, "R1 ready after reset", 32'({rdy_a, rdy_b}), 3);
        chk(!req_a && !req_b, "R1 no request in reset", 32'({req_a, req_b}), 0);
        chk(!lck_a && !lck_b, "R1 no lock in reset", 32'({lck_a, lck_b}), 0);
        chk(!rsp_a && !rsp_b, "R1 no response in reset", 32'({rsp_a, rsp_b}), 0);
        rst_n = 1'b1;

        // R3 byte: set bit 5 of byte 0x10, then read it and a neighbour
        op(0, 32'h2200_0000 + 32'h10 * 32 + 5 * 4, 2'd0, 1, 1, 0);
        rd(0, 32'h2200_0000 + 32'h10 * 32 + 5 * 4, 2'd0);
        rd(0, 32'h2200_0000 + 32'h10 * 32 + 6 * 4, 2'd0);
        // R3 halfword and word at the top bit indices
        op(0, 32'h2200_0000 + 32'h40 * 32 + 15 * 4, 2'd1, 1, 0, 0);
        rd(0, 32'h2200_0000 + 32'h40 * 32 + 15 * 4, 2'd1);
        op(0, 32'h2200_0000 + 32'h80 * 32 + 31 * 4, 2'd2, 1, 1, 0);
        rd(0, 32'h2200_0000 + 32'h80 * 32 + 31 * 4, 2'd2);
        // R4 size code 3 handled as word
        op(0, 32'h2200_0000 + 32'h84 * 32 + 9 * 4, 2'd3, 1, 0, 0);
        rd(0, 32'h2200_0000 + 32'h84 * 32 + 9 * 4, 2'd2);
        // R2 top of window and address bits above bit 24 ignored
        op(0, 32'h23FF_FFFC, 2'd0, 1, 0, 0);
        rd(0, 32'hFDFF_FFFC, 2'd0);
        op(0, 32'hFE00_0124, 2'd1, 1, 1, 0);
        // R10 peripheral instance with the same offsets
        op(1, 32'h4200_0000 + 32'h10 * 32 + 5 * 4, 2'd0, 1, 0, 0);
        rd(1, 32'h4200_0000 + 32'h10 * 32 + 5 * 4, 2'd0);
        op(1, 32'h4200_0000 + 32'h33 * 32 + 20 * 4, 2'd2, 1, 1, 0);
        rd(1, 32'h4200_0000 + 32'h33 * 32 + 20 * 4, 2'd2);
        // R9 upstream request held while busy is not taken
        op(0, 32'h2200_0000 + 32'h200 * 32 + 3 * 4, 2'd2, 1, 1, 1);
        op(1, 32'h4200_0000 + 32'h201 * 32 + 2 * 4, 2'd1, 1, 1, 1);
        rd(0, 32'h2200_0000 + (32'h200 ^ 32'h1F04 / 32) * 32, 2'd0);

        // random mix on a small target area so bits are revisited
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            a = {6'b0, 1'b1, ($urandom_range(0, 1) != 0) ? 5'h1F : 5'h00,
                 15'h0, 5'($urandom_range(0, 31)), 2'($urandom_range(0, 3))}
                | 32'($urandom_range(0, 63) << 7);
            a = (a & 32'h01FF_FFFF) | ($urandom_range(0, 1) != 0 ? 32'h2200_0000 : 32'h8200_0000);
            op($urandom_range(0, 1) != 0, a, 2'($urandom_range(0, 3)),
               $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
               $urandom_range(0, 7) == 0);
        end
        repeat (4) @(posedge clk);
        summary();
    end

endmodule